// File: doc/BRIEF.md
# Streaming ADPCM Sample Decoder

This block sits beside a DSP core and turns a compressed audio stream in external byte-wide memory into 16-bit samples, one per read of its data port. The core sets up a format code, a loop region (start and end) and a current position through a small register port. After that, each read on the data port fetches the bytes it needs, decodes them and returns a sample. The read port stalls, with ready low, until the sample exists.

In ADPCM mode the current position counts 4-bit codes. At the start of every 16-code frame the block fetches a header byte on its own. The low half of that byte gives a shift and the high half picks one of the coefficient pairs. Each code is scaled, added to a rounded two-tap prediction from the last two outputs, and clamped to a symmetric range. The result then shifts into the history pair. In 16-bit PCM mode the position counts bytes and each read returns a big-endian word, which also shifts into the history. Any other format code returns a big-endian word, leaves the history alone and flags an error. After every read, a position that has reached the end of the region jumps back to its start.

Top module: `adpcm_accel`

## Requirements
- R1: After reset every register reads zero, rd_ready is high, and rd_valid and mem_req are low.
- R2: An ADPCM read whose position has low four bits equal to zero first fetches the header byte at byte address ((position with low four bits cleared) >> 1). It stores that byte in the header register (index 7) and advances the position by 2 before decoding.
- R3: The code for an ADPCM read comes from the byte at address position >> 1. It is bits 7:4 when position bit 0 is 0 and bits 3:0 when it is 1. A code of 8 or more stands for that value minus 16.
- R4: The ADPCM sample is code * 2^h[3:0] + ((1024 + c1*y1 + c2*y2) >>> 11), where h is the header register. The pair is k = h[7:4] modulo the pair count, with c1 at register 16+2k and c2 at 17+2k. y1 is the first history register (index 8) and y2 is the second (index 9).
- R5: An ADPCM sample above 32767 returns 0x7FFF, and one below -32767 returns 0x8001.
- R6: Each ADPCM or PCM read moves the first history value into the second and puts the returned sample in the first. An ADPCM read advances the position by 1.
- R7: With format 0x000A a read returns (byte[position] << 8) | byte[position+1] and advances the position by 2.
- R8: Any format code other than 0x0000 and 0x000A returns the same big-endian word and advances by 2. It leaves both history registers unchanged and raises rd_err in the cycle rd_valid is high.
- R9: After the advance, a position greater than or equal to the end address (registers 3 high, 4 low) is replaced by the start address (registers 1 high, 2 low). The position is read back at registers 5 (high) and 6 (low).
- R10: rd_ready is high only when no read is in progress, and a read is taken when rd_req and rd_ready are both high. Each read taken gives exactly one single-cycle rd_valid pulse. Register writes made while rd_ready is low have no effect.
- R11: Once mem_req is raised it stays high with mem_addr unchanged until a cycle with mem_rvalid high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe, honoured only while rd_ready is high |
| cfg_addr | input | RAW | Register index for write and readback |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Register readback at cfg_addr, combinational |
| rd_req | input | 1 | Sample read request |
| rd_ready | output | 1 | Block idle, request can be taken |
| rd_valid | output | 1 | Sample on rd_data, one cycle |
| rd_data | output | 16 | Returned sample |
| rd_err | output | 1 | Unknown format code for this read, with rd_valid |
| mem_req | output | 1 | External byte read request |
| mem_addr | output | 32 | External byte address |
| mem_rvalid | input | 1 | External byte returned this cycle |
| mem_rdata | input | 8 | External byte |

## Verification
The decoder is driven with an ADPCM stream that starts on a frame boundary and runs across the next one, which shows that headers are fetched only at multiples of 16. A second stream starts mid-frame at an odd position, wraps into a new frame, and uses a header whose top bit is set, which separates the high and low code and the pair modulo. A PCM stream and an unknown format code separate history update from history hold at the same wrap behaviour. Saturating histories of both signs, together with a register write made during a busy read, pin down the clamp limits and the rule that writes are dropped while a read is in progress.

// File: rtl/adpcm_accel_pkg.sv
package adpcm_accel_pkg;

  localparam int IDX_FMT  = 0;
  localparam int IDX_STH  = 1;
  localparam int IDX_STL  = 2;
  localparam int IDX_ENH  = 3;
  localparam int IDX_ENL  = 4;
  localparam int IDX_CUH  = 5;
  localparam int IDX_CUL  = 6;
  localparam int IDX_HDR  = 7;
  localparam int IDX_HY1  = 8;
  localparam int IDX_HY2  = 9;
  localparam int IDX_COEF = 16;

  localparam logic [15:0] FMT_ADPCM = 16'h0000;
  localparam logic [15:0] FMT_PCM16 = 16'h000A;

  typedef enum logic [2:0] {ST_IDLE, ST_HDR, ST_NIB, ST_WHI, ST_WLO} acc_state_e;
  typedef enum logic [1:0] {MD_ADPCM, MD_PCM, MD_RAW} acc_mode_e;

  // Scaled code plus rounded two-tap prediction, saturated symmetrically.
  function automatic logic [15:0] adpcm_predict(
    input logic [7:0] hdr, input logic [3:0] code,
    input logic signed [15:0] c1, input logic signed [15:0] c2,
    input logic signed [15:0] y1, input logic signed [15:0] y2);
    logic signed [20:0] step;
    logic signed [33:0] acc;
    logic signed [33:0] tot;
    step = $signed({{17{code[3]}}, code}) <<< hdr[3:0];
    acc  = 34'sd1024 + c1 * y1 + c2 * y2;
    tot  = (acc >>> 11) + $signed({{13{step[20]}}, step});
    if (tot > 34'sd32767)       return 16'h7FFF;
    else if (tot < -34'sd32767) return 16'h8001;
    else                        return tot[15:0];
  endfunction

endpackage

// File: rtl/adpcm_accel_regfile.sv
module adpcm_accel_regfile
  import adpcm_accel_pkg::*;
#(
  parameter int NPAIR = 8,
  localparam int RAW = $clog2(IDX_COEF + 2 * NPAIR),
  localparam int KW  = $clog2(NPAIR),
  localparam int NCO = 2 * NPAIR
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              idle,
  input  logic              cfg_we,
  input  logic [RAW-1:0]    cfg_addr,
  input  logic [15:0]       cfg_wdata,
  output logic [15:0]       cfg_rdata,
  input  logic              upd_hdr_en,
  input  logic [7:0]        upd_hdr,
  input  logic              upd_pos_en,
  input  logic [31:0]       upd_pos,
  input  logic              upd_hist_en,
  input  logic [15:0]       upd_hist,
  output logic [15:0]       fmt,
  output logic [31:0]       start_a,
  output logic [31:0]       end_a,
  output logic [31:0]       cur_a,
  output logic [7:0]        hdr,
  output logic [15:0]       hist1,
  output logic [15:0]       hist2,
  output logic [15:0]       coef1,
  output logic [15:0]       coef2
);

  logic [15:0] coef_q [NCO];
  logic        wr_ok;
  logic [KW-1:0]  pair;
  logic [RAW-1:0] coff;

  assign wr_ok = cfg_we && idle;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fmt <= '0; start_a <= '0; end_a <= '0; cur_a <= '0;
      hdr <= '0; hist1 <= '0; hist2 <= '0;
    end else begin
      if (wr_ok) begin
        case (int'(cfg_addr))
          IDX_FMT: fmt            <= cfg_wdata;
          IDX_STH: start_a[31:16] <= cfg_wdata;
          IDX_STL: start_a[15:0]  <= cfg_wdata;
          IDX_ENH: end_a[31:16]   <= cfg_wdata;
          IDX_ENL: end_a[15:0]    <= cfg_wdata;
          IDX_CUH: cur_a[31:16]   <= cfg_wdata;
          IDX_CUL: cur_a[15:0]    <= cfg_wdata;
          IDX_HDR: hdr            <= cfg_wdata[7:0];
          IDX_HY1: hist1          <= cfg_wdata;
          IDX_HY2: hist2          <= cfg_wdata;
          default: ;
        endcase
      end
      if (upd_hdr_en) hdr <= upd_hdr;
      if (upd_pos_en) cur_a <= upd_pos;
      if (upd_hist_en) begin
        hist2 <= hist1;
        hist1 <= upd_hist;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NCO; i++) begin
      if (!rst_n) coef_q[i] <= '0;
      else if (wr_ok && int'(cfg_addr) == IDX_COEF + i) coef_q[i] <= cfg_wdata;
    end
  end

  assign pair  = hdr[4 +: KW];
  assign coef1 = coef_q[{pair, 1'b0}];
  assign coef2 = coef_q[{pair, 1'b1}];

  always_comb begin
    coff = cfg_addr - RAW'(IDX_COEF);
    case (int'(cfg_addr))
      IDX_FMT: cfg_rdata = fmt;
      IDX_STH: cfg_rdata = start_a[31:16];
      IDX_STL: cfg_rdata = start_a[15:0];
      IDX_ENH: cfg_rdata = end_a[31:16];
      IDX_ENL: cfg_rdata = end_a[15:0];
      IDX_CUH: cfg_rdata = cur_a[31:16];
      IDX_CUL: cfg_rdata = cur_a[15:0];
      IDX_HDR: cfg_rdata = {8'h00, hdr};
      IDX_HY1: cfg_rdata = hist1;
      IDX_HY2: cfg_rdata = hist2;
      default: begin
        if (int'(cfg_addr) >= IDX_COEF && int'(coff) < NCO)
          cfg_rdata = coef_q[coff[KW:0]];
        else
          cfg_rdata = '0;
      end
    endcase
  end

  AST_WRAP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    upd_pos_en |-> (upd_pos < end_a) || (upd_pos == start_a)); // R9
  AST_HIST_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    upd_hist_en |=> hist2 == $past(hist1)); // R6
  AST_BUSY_NOWRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |=> $stable(fmt)); // R10

endmodule

// File: rtl/adpcm_accel_predictor.sv
module adpcm_accel_predictor
  import adpcm_accel_pkg::*;
(
  input  logic [7:0]  hdr,
  input  logic [3:0]  code,
  input  logic [15:0] coef1,
  input  logic [15:0] coef2,
  input  logic [15:0] hist1,
  input  logic [15:0] hist2,
  output logic [15:0] sample
);

  assign sample = adpcm_predict(hdr, code, $signed(coef1), $signed(coef2),
                                $signed(hist1), $signed(hist2));

endmodule

// File: rtl/adpcm_accel_seq.sv
module adpcm_accel_seq
  import adpcm_accel_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rd_req,
  output logic        rd_ready,
  output logic        rd_valid,
  output logic [15:0] rd_data,
  output logic        rd_err,
  output logic        mem_req,
  output logic [31:0] mem_addr,
  input  logic        mem_rvalid,
  input  logic [7:0]  mem_rdata,
  input  logic [15:0] fmt,
  input  logic [31:0] start_a,
  input  logic [31:0] end_a,
  input  logic [31:0] cur_a,
  input  logic [15:0] sample,
  output logic [3:0]  code,
  output logic        upd_hdr_en,
  output logic [7:0]  upd_hdr,
  output logic        upd_pos_en,
  output logic [31:0] upd_pos,
  output logic        upd_hist_en,
  output logic [15:0] upd_hist
);

  acc_state_e  st;
  acc_mode_e   mode_q;
  acc_mode_e   mode_d;
  logic [31:0] wa;
  logic [7:0]  hi_q;
  logic        fetched;
  logic        accept;
  logic        last_step;
  logic [15:0] word;
  logic [31:0] adv;

  assign rd_ready  = (st == ST_IDLE);
  assign accept    = rd_req && rd_ready;
  assign mem_req   = (st != ST_IDLE);
  assign fetched   = mem_req && mem_rvalid;
  assign last_step = fetched && (st == ST_NIB || st == ST_WLO);
  assign code      = wa[0] ? mem_rdata[3:0] : mem_rdata[7:4];
  assign word      = {hi_q, mem_rdata};

  always_comb begin
    if (fmt == FMT_ADPCM)      mode_d = MD_ADPCM;
    else if (fmt == FMT_PCM16) mode_d = MD_PCM;
    else                       mode_d = MD_RAW;
  end

  always_comb begin
    case (st)
      ST_HDR:  mem_addr = {1'b0, wa[31:4], 3'b000};
      ST_NIB:  mem_addr = {1'b0, wa[31:1]};
      ST_WLO:  mem_addr = wa + 32'd1;
      default: mem_addr = wa;
    endcase
  end

  assign adv         = (st == ST_NIB) ? wa + 32'd1 : wa + 32'd2;
  assign upd_pos     = (adv >= end_a) ? start_a : adv;
  assign upd_pos_en  = last_step;
  assign upd_hdr_en  = fetched && (st == ST_HDR);
  assign upd_hdr     = mem_rdata;
  assign upd_hist_en = fetched && (st == ST_NIB || (st == ST_WLO && mode_q == MD_PCM));
  assign upd_hist    = (st == ST_NIB) ? sample : word;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_IDLE; mode_q <= MD_ADPCM; wa <= '0; hi_q <= '0;
      rd_valid <= 1'b0; rd_data <= '0; rd_err <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      rd_err   <= 1'b0;
      case (st)
        ST_IDLE: if (accept) begin
          wa     <= cur_a;
          mode_q <= mode_d;
          if (mode_d == MD_ADPCM) st <= (cur_a[3:0] == 4'h0) ? ST_HDR : ST_NIB;
          else                    st <= ST_WHI;
        end
        ST_HDR: if (fetched) begin
          wa <= wa + 32'd2;
          st <= ST_NIB;
        end
        ST_NIB: if (fetched) begin
          rd_valid <= 1'b1;
          rd_data  <= sample;
          st       <= ST_IDLE;
        end
        ST_WHI: if (fetched) begin
          hi_q <= mem_rdata;
          st   <= ST_WLO;
        end
        ST_WLO: if (fetched) begin
          rd_valid <= 1'b1;
          rd_data  <= word;
          rd_err   <= (mode_q == MD_RAW);
          st       <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_rvalid |=> mem_req && $stable(mem_addr)); // R11
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid); // R10
  AST_CLAMP_SYM: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && mode_q == MD_ADPCM |-> rd_data != 16'h8000); // R5
  AST_ERR_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    rd_err |-> rd_valid && mode_q == MD_RAW); // R8

endmodule

// File: rtl/adpcm_accel.sv
module adpcm_accel
  import adpcm_accel_pkg::*;
#(
  parameter int NPAIR = 8,
  localparam int RAW = $clog2(IDX_COEF + 2 * NPAIR)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [RAW-1:0] cfg_addr,
  input  logic [15:0]    cfg_wdata,
  output logic [15:0]    cfg_rdata,
  input  logic           rd_req,
  output logic           rd_ready,
  output logic           rd_valid,
  output logic [15:0]    rd_data,
  output logic           rd_err,
  output logic           mem_req,
  output logic [31:0]    mem_addr,
  input  logic           mem_rvalid,
  input  logic [7:0]     mem_rdata
);

  logic [15:0] fmt, hist1, hist2, coef1, coef2, sample, upd_hist;
  logic [31:0] start_a, end_a, cur_a, upd_pos;
  logic [7:0]  hdr, upd_hdr;
  logic [3:0]  code;
  logic        upd_hdr_en, upd_pos_en, upd_hist_en;

  adpcm_accel_regfile #(.NPAIR(NPAIR)) regs_i (
    .clk(clk), .rst_n(rst_n), .idle(rd_ready),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .upd_hdr_en(upd_hdr_en), .upd_hdr(upd_hdr),
    .upd_pos_en(upd_pos_en), .upd_pos(upd_pos),
    .upd_hist_en(upd_hist_en), .upd_hist(upd_hist),
    .fmt(fmt), .start_a(start_a), .end_a(end_a), .cur_a(cur_a), .hdr(hdr),
    .hist1(hist1), .hist2(hist2), .coef1(coef1), .coef2(coef2)
  );

  adpcm_accel_predictor pred_i (
    .hdr(hdr), .code(code), .coef1(coef1), .coef2(coef2),
    .hist1(hist1), .hist2(hist2), .sample(sample)
  );

  adpcm_accel_seq seq_i (
    .clk(clk), .rst_n(rst_n),
    .rd_req(rd_req), .rd_ready(rd_ready), .rd_valid(rd_valid), .rd_data(rd_data), .rd_err(rd_err),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .fmt(fmt), .start_a(start_a), .end_a(end_a), .cur_a(cur_a), .sample(sample), .code(code),
    .upd_hdr_en(upd_hdr_en), .upd_hdr(upd_hdr), .upd_pos_en(upd_pos_en), .upd_pos(upd_pos),
    .upd_hist_en(upd_hist_en), .upd_hist(upd_hist)
  );

endmodule

// File: tb/adpcm_accel_tb_top.sv
`timescale 1ns/1ps
module adpcm_accel_tb_top;

  localparam int NPAIR = 8;
  localparam int RAW   = $clog2(16 + 2 * NPAIR);
  localparam int NSC   = 5;

  // Scenario table: stimulus per stream; expected samples come from the model below.
  localparam logic [15:0] SC_FMT   [NSC] = '{16'h0000, 16'h0000, 16'h000A, 16'h0005, 16'h0000};
  localparam logic [31:0] SC_START [NSC] = '{32'h0, 32'h20, 32'h10, 32'h40, 32'h0};
  localparam logic [31:0] SC_END   [NSC] = '{32'h40, 32'h38, 32'h18, 32'h100, 32'h30};
  localparam logic [31:0] SC_CUR   [NSC] = '{32'h0, 32'h35, 32'h12, 32'h44, 32'h7};
  localparam logic [7:0]  SC_HDR   [NSC] = '{8'h00, 8'hB3, 8'h00, 8'h00, 8'h2C};
  localparam logic [15:0] SC_H1    [NSC] = '{16'h0000, 16'h1234, 16'h0042, 16'h5555, 16'hFF00};
  localparam logic [15:0] SC_H2    [NSC] = '{16'h0000, 16'hF00D, 16'h0017, 16'hAAAA, 16'h0123};
  localparam logic [15:0] SC_CB    [NSC] = '{16'h0800, 16'hC123, 16'h0100, 16'h0200, 16'h7A00};
  localparam logic [15:0] SC_CS    [NSC] = '{16'h1F35, 16'h2B17, 16'h0001, 16'h0003, 16'h9113};
  localparam int          SC_N     [NSC] = '{20, 8, 6, 3, 12};

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           cfg_we = 1'b0;
  logic [RAW-1:0] cfg_addr = '0;
  logic [15:0]    cfg_wdata = '0;
  logic [15:0]    cfg_rdata;
  logic           rd_req = 1'b0;
  logic           rd_ready, rd_valid, rd_err, mem_req;
  logic [15:0]    rd_data;
  logic [31:0]    mem_addr;
  logic           mem_rvalid;
  logic [7:0]     mem_rdata;

  logic [7:0]  mem_b [256];
  logic [15:0] mreg [32];
  int          nchk = 0;
  int          nfail = 0;
  logic        pend = 1'b0;
  logic [31:0] pend_addr = '0;
  int          hold_err = 0;

  always #2 clk = ~clk;

  adpcm_accel #(.NPAIR(NPAIR)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .rd_req(rd_req), .rd_ready(rd_ready), .rd_valid(rd_valid),
    .rd_data(rd_data), .rd_err(rd_err), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  // Byte memory: answers one cycle after a request is seen.
  assign mem_rdata = mem_b[mem_addr[7:0]];
  always @(posedge clk) begin
    if (!rst_n) mem_rvalid <= 1'b0;
    else        mem_rvalid <= mem_req && !mem_rvalid;
  end
  always @(negedge clk) begin
    if (rst_n && pend && (!mem_req || mem_addr != pend_addr)) hold_err++;
    pend      <= mem_req && !mem_rvalid;
    pend_addr <= mem_addr;
  end

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [15:0] val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = RAW'(idx); cfg_wdata = val;
    @(negedge clk);
    cfg_we = 1'b0;
    mreg[idx] = (idx == 7) ? {8'h00, val[7:0]} : val;
  endtask

  task automatic rdreg(input int idx, output logic [15:0] v);
    cfg_addr = RAW'(idx);
    #0.5;
    v = cfg_rdata;
  endtask

  task automatic setup(input int s);
    wr(0, SC_FMT[s]);
    wr(1, SC_START[s][31:16]); wr(2, SC_START[s][15:0]);
    wr(3, SC_END[s][31:16]);   wr(4, SC_END[s][15:0]);
    wr(5, SC_CUR[s][31:16]);   wr(6, SC_CUR[s][15:0]);
    wr(7, {8'h00, SC_HDR[s]});
    wr(8, SC_H1[s]); wr(9, SC_H2[s]);
    for (int i = 0; i < 2 * NPAIR; i++) wr(16 + i, SC_CB[s] + 16'(i) * SC_CS[s]);
  endtask

  // Independent model of one read, written from the requirements.
  task automatic ref_read(output logic [15:0] d, output logic e);
    logic [31:0] a, ba;
    logic [7:0]  b;
    int          sn, k;
    longint      c1, c2, y1, y2, v;
    a = {mreg[5], mreg[6]};
    e = 1'b0;
    if (mreg[0] == 16'h0000) begin
      if (a[3:0] == 4'h0) begin
        ba = (a & ~32'hF) >> 1;
        mreg[7] = {8'h00, mem_b[ba[7:0]]};
        a = a + 2;
      end
      ba = a >> 1;
      b  = mem_b[ba[7:0]];
      sn = a[0] ? int'(b[3:0]) : int'(b[7:4]);
      if (sn > 7) sn = sn - 16;
      k  = int'(mreg[7][7:4]) % NPAIR;
      c1 = longint'($signed(mreg[16 + 2 * k]));
      c2 = longint'($signed(mreg[17 + 2 * k]));
      y1 = longint'($signed(mreg[8]));
      y2 = longint'($signed(mreg[9]));
      v  = longint'(sn) * (longint'(1) << mreg[7][3:0]) + ((64'sd1024 + c1 * y1 + c2 * y2) >>> 11);
      if (v > 32767) v = 32767;
      if (v < -32767) v = -32767;
      d = v[15:0];
      mreg[9] = mreg[8]; mreg[8] = d;
      a = a + 1;
    end else begin
      ba = a + 1;
      d = {mem_b[a[7:0]], mem_b[ba[7:0]]};
      if (mreg[0] == 16'h000A) begin
        mreg[9] = mreg[8]; mreg[8] = d;
      end else e = 1'b1;
      a = a + 2;
    end
    if (a >= {mreg[3], mreg[4]}) a = {mreg[1], mreg[2]};
    mreg[5] = a[31:16]; mreg[6] = a[15:0];
  endtask

  task automatic wait_valid(output logic [15:0] d, output logic e);
    int t = 0;
    while (!rd_valid && t < 200) begin
      @(negedge clk);
      t++;
    end
    if (!rd_valid) begin
      nchk++; nfail++;
      $display("FAIL R10 actual=no_rd_valid expected=rd_valid");
    end
    d = rd_data; e = rd_err;
  endtask

  task automatic do_read(output logic [15:0] d, output logic e);
    @(negedge clk);
    rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
    wait_valid(d, e);
  endtask

  task automatic read_and_check(input string tag);
    logic [15:0] d, ed, v;
    logic        e, ee;
    do_read(d, e);
    ref_read(ed, ee);
    chk(tag, {16'h0, d}, {16'h0, ed});
    chk("R8 err flag", {31'h0, e}, {31'h0, ee});
    rdreg(6, v); chk("R9 position low", {16'h0, v}, {16'h0, mreg[6]});
    rdreg(5, v); chk("R9 position high", {16'h0, v}, {16'h0, mreg[5]});
    rdreg(8, v); chk("R6 history1", {16'h0, v}, {16'h0, mreg[8]});
    rdreg(9, v); chk("R6 history2", {16'h0, v}, {16'h0, mreg[9]});
    rdreg(7, v); chk("R2 header", {16'h0, v}, {16'h0, mreg[7]});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog actual=running expected=finished");
    report();
    $finish;
  end

  initial begin
    logic [15:0] v, d;
    logic        e;
    for (int i = 0; i < 256; i++) mem_b[i] = 8'((i * 37 + 11) & 255);
    for (int i = 0; i < 32; i++) mreg[i] = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk("R1 rd_ready", {31'h0, rd_ready}, 32'h1);
    chk("R1 rd_valid", {31'h0, rd_valid}, 32'h0);
    chk("R1 mem_req", {31'h0, mem_req}, 32'h0);
    rdreg(0, v);  chk("R1 format reg", {16'h0, v}, 32'h0);
    rdreg(6, v);  chk("R1 position reg", {16'h0, v}, 32'h0);
    rdreg(8, v);  chk("R1 history reg", {16'h0, v}, 32'h0);
    rdreg(23, v); chk("R1 coef reg", {16'h0, v}, 32'h0);

    // Table walk: each stream scenario.
    for (int s = 0; s < NSC; s++) begin
      setup(s);
      for (int n = 0; n < SC_N[s]; n++) begin
        if (SC_FMT[s] == 16'h0000)      read_and_check("R3 R4 adpcm sample");
        else if (SC_FMT[s] == 16'h000A) read_and_check("R7 pcm word");
        else                            read_and_check("R8 unknown format word");
      end
    end

    // R5: positive saturation
    setup(0);
    wr(5, 16'h0); wr(6, 16'h3); wr(7, 16'h0);
    wr(8, 16'h7000); wr(9, 16'h7000);
    for (int i = 0; i < 2 * NPAIR; i++) wr(16 + i, 16'h7FFF);
    do_read(d, e);
    chk("R5 clamp high", {16'h0, d}, 32'h7FFF);
    // R5: negative saturation stops at -32767
    wr(5, 16'h0); wr(6, 16'h3);
    wr(8, 16'h9000); wr(9, 16'h9000);
    do_read(d, e);
    chk("R5 clamp low", {16'h0, d}, 32'h8001);

    // R10: busy read ignores a register write; ready low while busy
    setup(2);
    @(negedge clk);
    rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
    chk("R10 ready low while busy", {31'h0, rd_ready}, 32'h0);
    cfg_we = 1'b1; cfg_addr = RAW'(0); cfg_wdata = 16'h0000;
    @(negedge clk);
    cfg_we = 1'b0;
    wait_valid(d, e);
    begin
      logic [15:0] ed;
      logic        ee;
      ref_read(ed, ee);
      chk("R10 busy read data", {16'h0, d}, {16'h0, ed});
    end
    rdreg(0, v);
    chk("R10 write dropped while busy", {16'h0, v}, 32'h000A);
    @(negedge clk);
    chk("R10 ready after read", {31'h0, rd_ready}, 32'h1);

    // R11: memory request held stable until answered
    chk("R11 request hold violations", hold_err, 0);

    report();
    $finish;
  end

endmodule